// File: doc/BRIEF.md
# Halt-Run-Resume Quick Command Sequencer

This block carries out one optional debug command that briefly stops a running hart, runs the small debug program held in the program buffer, and lets the hart continue. A command arrives as a single-cycle valid strobe with a type code. When the type code marks the quick command and the sequencer is idle, it checks the hart's run state. If the hart is running, the sequencer asks it to halt. Once the hart reports that it has halted, the sequencer asks the program-buffer runner to execute. When that finishes, it asks the hart to resume.

Run control is modelled as three request/acknowledge pairs: halt, program run and resume. A request stays high until its acknowledge is seen. The halt acknowledge carries a cause flag, so the sequencer can tell its own halt from one caused by some other event, such as a breakpoint. Some failures abort the command at once. A fault inside the debug program is different: it only records an error, and the hart is still resumed. The block has no path to the data or argument registers, so the command cannot change them.

When the `IMPL` parameter is 0, the command is not supported. Every such command is then answered at once with the unsupported error code.

Top module: `qx_quick_ctrl`

## Requirements
- R1: A command whose type code is not 1 is ignored. Busy stays 0, done stays 0 and no request is raised.
- R2: A type-1 command accepted while idle, with `hart_halted`=0 and `IMPL`=1, sets busy and `halt_req` in the next cycle and clears `err_code` to 0. `halt_req` then holds until `halt_ack`.
- R3: A type-1 command accepted while `hart_halted`=1 (and `IMPL`=1) pulses done in the next cycle with `err_code`=4. Busy stays 0 and `halt_req` is never raised.
- R4: A `halt_ack` with `halt_cause_dbg`=1 (a halt this block asked for) drops `halt_req` and raises `prog_req` in the next cycle.
- R5: A `halt_ack` with `halt_cause_dbg`=0 (a halt from another cause) aborts the command. In the next cycle done pulses with `err_code`=4 and busy is 0. No program run or resume request follows.
- R6: A `prog_done` drops `prog_req` and raises `resume_req` in the next cycle. `err_code` becomes 3 when `prog_exc`=1 and stays 0 otherwise. An exception therefore never skips the resume.
- R7: A `resume_ack` ends the command. In the next cycle done pulses for one cycle and busy falls. `err_code` keeps its final value until the next type-1 command is accepted.
- R8: At most one of `halt_req`, `prog_req` and `resume_req` is high at a time. Each is high only while busy, and they come in the order halt, program, resume.
- R9: With `IMPL`=0, a type-1 command pulses done in the next cycle with `err_code`=2. Busy stays 0 and no request is raised.
- R10: A command strobe that arrives while busy is ignored. The sequence in progress continues unchanged and no extra done is produced.
- R11: Busy falls only in the cycle in which done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | TYPE_W | Command type code; 1 selects this command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 none, 2 unsupported, 3 exception, 4 halt/resume |
| hart_halted | input | 1 | Hart run state, sampled at acceptance |
| halt_req | output | 1 | Halt request to the hart |
| halt_ack | input | 1 | Hart reports it has halted |
| halt_cause_dbg | input | 1 | With halt_ack: 1 when the halt was requested by this block |
| prog_req | output | 1 | Request to run the program buffer |
| prog_done | input | 1 | Program buffer run finished |
| prog_exc | input | 1 | With prog_done: the program raised an exception |
| resume_req | output | 1 | Resume request to the hart |
| resume_ack | input | 1 | Hart reports it has resumed |

## Verification
The bench builds two copies of the block that receive the same command inputs. One copy has `IMPL`=1 and the other has `IMPL`=0, and the default 8-bit type code is used throughout. The supported copy is driven through every path of the handshake: the halt-cause split, a clean program run, a faulting program run, a hart that is already halted, and a strobe that arrives mid-sequence. The stub copy shows the immediate unsupported answer to each of those same strobes.

// File: rtl/qx_pkg.sv
package qx_pkg;

  typedef enum logic [1:0] {
    QX_IDLE   = 2'd0,
    QX_HALT   = 2'd1,
    QX_PROG   = 2'd2,
    QX_RESUME = 2'd3
  } qx_state_e;

  localparam int unsigned QX_ERR_W      = 3;
  localparam int unsigned QX_QUICK_TYPE = 1;

  localparam logic [QX_ERR_W-1:0] QX_ERR_NONE    = 3'd0;
  localparam logic [QX_ERR_W-1:0] QX_ERR_UNSUP   = 3'd2;
  localparam logic [QX_ERR_W-1:0] QX_ERR_EXC     = 3'd3;
  localparam logic [QX_ERR_W-1:0] QX_ERR_HALTRES = 3'd4;

  typedef struct packed {
    logic run;
    logic halted;
    logic unimpl;
  } qx_class_t;

  // Split an accepted quick command into its three possible outcomes.
  function automatic qx_class_t qx_classify(input logic hit, input logic halted,
                                            input logic impl);
    qx_class_t c;
    c.run    = hit && impl && !halted;
    c.halted = hit && impl && halted;
    c.unimpl = hit && !impl;
    return c;
  endfunction

  // Error left behind by a finished program-buffer run.
  function automatic logic [QX_ERR_W-1:0] qx_prog_err(input logic exc);
    return exc ? QX_ERR_EXC : QX_ERR_NONE;
  endfunction

endpackage

// File: rtl/qx_cmd_decode.sv
module qx_cmd_decode
  import qx_pkg::*;
#(
  parameter int unsigned TYPE_W = 8,
  parameter bit          IMPL   = 1'b1
) (
  input  logic              cmd_valid,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic              idle,
  input  logic              hart_halted,
  output logic              start_run,
  output logic              rej_halted,
  output logic              rej_unimpl
);

  localparam logic [TYPE_W-1:0] QUICK_CODE = TYPE_W'(QX_QUICK_TYPE);

  logic      hit;
  qx_class_t cls;

  assign hit = cmd_valid && idle && (cmd_type == QUICK_CODE);

  always_comb begin
    cls = qx_classify(hit, hart_halted, IMPL);
  end

  assign start_run  = cls.run;
  assign rej_halted = cls.halted;
  assign rej_unimpl = cls.unimpl;

endmodule

// File: rtl/qx_seq_fsm.sv
module qx_seq_fsm
  import qx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_run,
  input  logic      halt_ack,
  input  logic      halt_cause_dbg,
  input  logic      prog_done,
  input  logic      resume_ack,
  output qx_state_e state,
  output logic      halt_req,
  output logic      prog_req,
  output logic      resume_req,
  output logic      evt_own_halt,
  output logic      evt_foreign_halt,
  output logic      evt_prog_end,
  output logic      evt_resume_end
);

  qx_state_e state_q, state_d;

  // Named events, each tied to the phase that can observe it.
  assign evt_own_halt     = (state_q == QX_HALT) && halt_ack && halt_cause_dbg;
  assign evt_foreign_halt = (state_q == QX_HALT) && halt_ack && !halt_cause_dbg;
  assign evt_prog_end     = (state_q == QX_PROG) && prog_done;
  assign evt_resume_end   = (state_q == QX_RESUME) && resume_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      QX_IDLE:   if (start_run) state_d = QX_HALT;
      QX_HALT: begin
        if (evt_own_halt)          state_d = QX_PROG;
        else if (evt_foreign_halt) state_d = QX_IDLE;
      end
      QX_PROG:   if (evt_prog_end)   state_d = QX_RESUME;
      QX_RESUME: if (evt_resume_end) state_d = QX_IDLE;
      default:   state_d = QX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= QX_IDLE;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign halt_req   = (state_q == QX_HALT);
  assign prog_req   = (state_q == QX_PROG);
  assign resume_req = (state_q == QX_RESUME);

endmodule

// File: rtl/qx_err_track.sv
module qx_err_track
  import qx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_run,
  input  logic                rej_halted,
  input  logic                rej_unimpl,
  input  logic                evt_foreign_halt,
  input  logic                evt_prog_end,
  input  logic                prog_exc,
  input  logic                evt_resume_end,
  output logic [QX_ERR_W-1:0] err_code,
  output logic                done
);

  logic [QX_ERR_W-1:0] err_q, err_d;
  logic                done_d;

  always_comb begin
    err_d  = err_q;
    done_d = 1'b0;
    if (start_run) begin
      err_d = QX_ERR_NONE;
    end else if (rej_unimpl) begin
      err_d  = QX_ERR_UNSUP;
      done_d = 1'b1;
    end else if (rej_halted || evt_foreign_halt) begin
      err_d  = QX_ERR_HALTRES;
      done_d = 1'b1;
    end else if (evt_prog_end) begin
      err_d = qx_prog_err(prog_exc);
    end else if (evt_resume_end) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= QX_ERR_NONE;
      done  <= 1'b0;
    end else begin
      err_q <= err_d;
      done  <= done_d;
    end
  end

  assign err_code = err_q;

endmodule

// File: rtl/qx_quick_ctrl.sv
module qx_quick_ctrl
  import qx_pkg::*;
#(
  parameter int unsigned TYPE_W = 8,
  parameter bit          IMPL   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [TYPE_W-1:0] cmd_type,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code,
  input  logic              hart_halted,
  output logic              halt_req,
  input  logic              halt_ack,
  input  logic              halt_cause_dbg,
  output logic              prog_req,
  input  logic              prog_done,
  input  logic              prog_exc,
  output logic              resume_req,
  input  logic              resume_ack
);

  qx_state_e state;
  logic      start_run, rej_halted, rej_unimpl;
  logic      evt_own_halt, evt_foreign_halt, evt_prog_end, evt_resume_end;

  qx_cmd_decode #(.TYPE_W(TYPE_W), .IMPL(IMPL)) u_decode (
    .cmd_valid   (cmd_valid),
    .cmd_type    (cmd_type),
    .idle        (state == QX_IDLE),
    .hart_halted (hart_halted),
    .start_run   (start_run),
    .rej_halted  (rej_halted),
    .rej_unimpl  (rej_unimpl)
  );

  qx_seq_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_run        (start_run),
    .halt_ack         (halt_ack),
    .halt_cause_dbg   (halt_cause_dbg),
    .prog_done        (prog_done),
    .resume_ack       (resume_ack),
    .state            (state),
    .halt_req         (halt_req),
    .prog_req         (prog_req),
    .resume_req       (resume_req),
    .evt_own_halt     (evt_own_halt),
    .evt_foreign_halt (evt_foreign_halt),
    .evt_prog_end     (evt_prog_end),
    .evt_resume_end   (evt_resume_end)
  );

  qx_err_track u_err (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_run        (start_run),
    .rej_halted       (rej_halted),
    .rej_unimpl       (rej_unimpl),
    .evt_foreign_halt (evt_foreign_halt),
    .evt_prog_end     (evt_prog_end),
    .prog_exc         (prog_exc),
    .evt_resume_end   (evt_resume_end),
    .err_code         (err_code),
    .done             (done)
  );

  assign busy = (state != QX_IDLE);

endmodule

// File: rtl/qx_quick_ctrl_chk.sv
module qx_quick_ctrl_chk #(
  parameter int unsigned TYPE_W = 8,
  parameter bit          IMPL   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [TYPE_W-1:0] cmd_type,
  input logic              busy,
  input logic              done,
  input logic [2:0]        err_code,
  input logic              hart_halted,
  input logic              halt_req,
  input logic              halt_ack,
  input logic              halt_cause_dbg,
  input logic              prog_req,
  input logic              prog_done,
  input logic              prog_exc,
  input logic              resume_req,
  input logic              resume_ack,
  input logic              start_run,
  input logic              rej_halted,
  input logic              rej_unimpl
);

  logic is_quick;
  assign is_quick = cmd_valid && (cmd_type == TYPE_W'(1));

  p_other_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !is_quick) |=> (!busy && !done));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (IMPL && !busy && is_quick && !hart_halted) |=> (busy && halt_req && err_code == 3'd0));

  p_halted_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (IMPL && !busy && is_quick && hart_halted) |=> (done && !busy && !halt_req && err_code == 3'd4));

  p_own_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && halt_ack && halt_cause_dbg) |=> (prog_req && !halt_req));

  p_foreign_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && halt_ack && !halt_cause_dbg) |=> (done && !busy && !prog_req && err_code == 3'd4));

  p_prog_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && prog_done && prog_exc) |=> (resume_req && err_code == 3'd3));

  p_prog_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && prog_done && !prog_exc) |=> (resume_req && err_code == 3'd0));

  p_resume_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && resume_ack) |=> (done && !busy));

  p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, prog_req, resume_req}));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || prog_req || resume_req) |-> busy);

  p_unimpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!IMPL && !busy && is_quick) |=> (done && !busy && err_code == 3'd2));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !halt_ack && !prog_done && !resume_ack) |=> (busy && !done));

  p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_decode_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_run, rej_halted, rej_unimpl}));

endmodule

bind qx_quick_ctrl qx_quick_ctrl_chk #(.TYPE_W(TYPE_W), .IMPL(IMPL)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_type       (cmd_type),
  .busy           (busy),
  .done           (done),
  .err_code       (err_code),
  .hart_halted    (hart_halted),
  .halt_req       (halt_req),
  .halt_ack       (halt_ack),
  .halt_cause_dbg (halt_cause_dbg),
  .prog_req       (prog_req),
  .prog_done      (prog_done),
  .prog_exc       (prog_exc),
  .resume_req     (resume_req),
  .resume_ack     (resume_ack),
  .start_run      (start_run),
  .rej_halted     (rej_halted),
  .rej_unimpl     (rej_unimpl)
);

// File: tb/qx_quick_ctrl_test.sv
`timescale 1ns/1ps
module qx_quick_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_type = 8'd0;
  logic       hart_halted = 1'b0;
  logic       halt_ack = 1'b0, halt_cause_dbg = 1'b0;
  logic       prog_done = 1'b0, prog_exc = 1'b0, resume_ack = 1'b0;

  logic       busy, done, halt_req, prog_req, resume_req;
  logic [2:0] err_code;
  logic       s_busy, s_done, s_halt_req, s_prog_req, s_resume_req;
  logic [2:0] s_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  qx_quick_ctrl #(.TYPE_W(8), .IMPL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .busy(busy), .done(done), .err_code(err_code), .hart_halted(hart_halted),
    .halt_req(halt_req), .halt_ack(halt_ack), .halt_cause_dbg(halt_cause_dbg),
    .prog_req(prog_req), .prog_done(prog_done), .prog_exc(prog_exc),
    .resume_req(resume_req), .resume_ack(resume_ack)
  );

  qx_quick_ctrl #(.TYPE_W(8), .IMPL(1'b0)) uut_stub (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .busy(s_busy), .done(s_done), .err_code(s_err), .hart_halted(1'b0),
    .halt_req(s_halt_req), .halt_ack(1'b0), .halt_cause_dbg(1'b0),
    .prog_req(s_prog_req), .prog_done(1'b0), .prog_exc(1'b0),
    .resume_req(s_resume_req), .resume_ack(1'b0)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [7:0] t);
    cmd_valid = 1'b1;
    cmd_type  = t;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R7 reset busy/done", {busy, done}, 0);
    chk(err_code == 3'd0, "R7 reset err", err_code, 0);
    chk({halt_req, prog_req, resume_req} == 3'b000, "R8 reset requests",
        {halt_req, prog_req, resume_req}, 0);
  endtask

  task automatic t_other_type();
    issue(8'd2);
    chk(!busy && !done, "R1 type 2 busy/done", {busy, done}, 0);
    chk(!halt_req, "R1 type 2 halt_req", halt_req, 0);
    chk(!s_done && !s_busy, "R1 stub ignores type 2", {s_busy, s_done}, 0);
    issue(8'd0);
    chk(!busy && !done && !halt_req, "R1 type 0 ignored", {busy, done, halt_req}, 0);
  endtask

  task automatic t_halted_start();
    hart_halted = 1'b1;
    issue(8'd1);
    hart_halted = 1'b0;
    chk(done && err_code == 3'd4, "R3 halted start err", err_code, 4);
    chk(!busy && !halt_req, "R3 halted start no halt", {busy, halt_req}, 0);
    chk(s_done && s_err == 3'd2 && !s_busy, "R9 stub unsupported", s_err, 2);
    step();
    chk(!done && !busy && !halt_req, "R3 no follow-up", {done, busy, halt_req}, 0);
    chk(!s_done && !s_halt_req && !s_prog_req && !s_resume_req, "R9 stub no requests",
        {s_done, s_halt_req, s_prog_req, s_resume_req}, 0);
  endtask

  task automatic t_normal(input bit exc);
    int e = exc ? 3 : 0;
    issue(8'd1);
    chk(busy && halt_req, "R2 accept", {busy, halt_req}, 3);
    chk(err_code == 3'd0, "R2 err cleared", err_code, 0);
    chk(s_done && s_err == 3'd2, "R9 stub answers", s_err, 2);
    step();
    chk(halt_req && !prog_req, "R2 halt_req held", {halt_req, prog_req}, 2);
    halt_ack = 1'b1; halt_cause_dbg = 1'b1;
    step();
    halt_ack = 1'b0; halt_cause_dbg = 1'b0;
    chk(prog_req && !halt_req, "R4 own halt starts program", {halt_req, prog_req}, 1);
    chk({halt_req, prog_req, resume_req} == 3'b010, "R8 one request",
        {halt_req, prog_req, resume_req}, 2);
    issue(8'd1);
    chk(prog_req && busy && !done, "R10 strobe while busy ignored", {prog_req, busy, done}, 6);
    prog_done = 1'b1; prog_exc = exc;
    step();
    prog_done = 1'b0; prog_exc = 1'b0;
    chk(resume_req && !prog_req && busy, "R6 resume after program", {prog_req, resume_req}, 1);
    chk(int'(err_code) == e, "R6 program error", err_code, e);
    resume_ack = 1'b1;
    step();
    resume_ack = 1'b0;
    chk(done && !busy, "R7 R11 end on resume ack", {busy, done}, 1);
    chk(!resume_req, "R8 resume dropped", resume_req, 0);
    chk(int'(err_code) == e, "R7 final err", err_code, e);
    step();
    chk(!done && int'(err_code) == e, "R7 err held, done one cycle", err_code, e);
  endtask

  task automatic t_foreign_halt();
    issue(8'd1);
    chk(busy && err_code == 3'd0, "R2 err cleared on new command", err_code, 0);
    halt_ack = 1'b1; halt_cause_dbg = 1'b0;
    step();
    halt_ack = 1'b0;
    chk(done && err_code == 3'd4, "R5 foreign halt err", err_code, 4);
    chk(!busy && !prog_req, "R5 aborted", {busy, prog_req}, 0);
    step();
    chk(!prog_req && !resume_req && !busy, "R5 no program or resume",
        {prog_req, resume_req, busy}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_other_type();
    t_halted_start();
    t_normal(1'b0);
    t_normal(1'b1);
    t_foreign_halt();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule